// File: doc/BRIEF.md
# Banked Data-Register File with Direct and Pointer Addressing

This block holds the data registers of a small 8-bit controller and forms the file address for every data access the CPU makes. The register space is 512 bytes, seen as four banks of 128. A request carries a 7-bit file field taken from the instruction word. Normally that field is joined under two bank-select bits held in the status register. When the field names the pointer port, the access goes instead to the byte chosen by an 8-bit pointer register, with a separate status bit above it as the ninth address bit.

Three locations sit at the same offset in every bank: the pointer port, the status register and the pointer register. They can therefore be reached whatever the bank bits hold. The CPU gets four operations: read, write, set one bit and clear one bit. Bit operations are done as a read of the whole byte, a change to one bit and a write of the byte back. The three condition flags in the low status bits are loaded only by the ALU flag port.

Requests enter a two-stage pipeline, one per cycle, with no stall. The storage array is a single synchronous-read memory that can map to block RAM. Every write is committed in the second stage, and results are forwarded so that each access sees the effect of the one before it.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears the status register and the pointer register to 0x00, and `rd_vld` is low after reset.
- R2: When `req_fld` is not 0x00, 0x03 or 0x04, the access reaches the storage byte at address {status[6:5], req_fld}. Each of the four banks holds its own 125 bytes.
- R3: When `req_fld` is 0x00, the access reaches address {status[7], pointer}. Reads return that byte and writes change it, including when that address lands on the status or pointer register.
- R4: File offset 0x03 is the status register and offset 0x04 is the pointer register, in every bank, whether reached directly or through the pointer.
- R5: A pointer access whose target has low seven bits 0x00 reads 0x00, and a write or bit operation on it changes nothing.
- R6: `req_op` codes are 0 read, 1 write, 2 set bit, 3 clear bit. Codes 2 and 3 change only bit `req_bit` of the addressed byte and keep its other seven bits.
- R7: Status bits [2:0] change only through `alu_flag_we`/`alu_flags`, and bus writes to status change only bits [7:3]. A flag load and a bus write to status in the same cycle both take effect.
- R8: A read request sampled at a rising edge yields `rd_vld` high and its byte on `rd_data` after the following rising edge.
- R9: Requests may be issued back to back. Each one sees the data, pointer and bank bits as left by every earlier request, with no stall.
- R10: `rd_vld` is raised only for read requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 set bit, 3 clear bit |
| req_fld | input | 7 | File field from the instruction word |
| req_wdata | input | 8 | Write data for op 1 |
| req_bit | input | 3 | Bit index for ops 2 and 3 |
| alu_flag_we | input | 1 | Load the condition flags |
| alu_flags | input | 3 | New values for status bits [2:0] |
| rd_vld | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| status_q | output | 8 | Current status register |
| ptr_q | output | 8 | Current pointer register |

## Verification
Two functions can fall in the same cycle: the ALU flag load, and a bus write or bit operation on the status register that is sitting in the commit stage. The bench drives both in one cycle. It writes 0xFF to status while loading new flags, then sets and clears status bits while the flags change again. It judges each result by reading status back: the bank bits must carry the bus value and bits [2:0] the ALU value. Separately, pointer and bank writes are followed at once by dependent accesses, to confirm the address is formed from the value still being committed.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_BSET = 2'd2,
    OP_BCLR = 2'd3
  } rf_op_e;

  typedef enum logic [1:0] {
    K_RAM  = 2'd0,
    K_NULL = 2'd1,
    K_STAT = 2'd2,
    K_PTR  = 2'd3
  } rf_kind_e;

  // status layout
  localparam int STAT_RP_LO = 5;  // lowest direct bank bit
  localparam int STAT_IRP   = 7;  // pointer-mode bank bit
  localparam int FLAG_W     = 3;  // ALU-owned flag bits

endpackage

// File: rtl/rf_addr_gen.sv
module rf_addr_gen
  import banked_rf_pkg::*;
#(
  parameter int DW       = 8,
  parameter int FLD_W    = 7,
  parameter int BANK_W   = 2,
  parameter int PTR_W    = 8,
  parameter int IND_OFS  = 0,
  parameter int STAT_OFS = 3,
  parameter int PTR_OFS  = 4
) (
  input  logic [FLD_W-1:0]        fld,
  input  logic [DW-1:0]           stat,
  input  logic [PTR_W-1:0]        ptr,
  output logic [FLD_W+BANK_W-1:0] addr,
  output rf_kind_e                kind
);
  localparam int AW    = FLD_W + BANK_W;
  localparam int IHI_W = AW - PTR_W;

  logic [FLD_W-1:0] low;

  always_comb begin
    if (fld == FLD_W'(IND_OFS))
      addr = {stat[STAT_IRP -: IHI_W], ptr};
    else
      addr = {stat[STAT_RP_LO +: BANK_W], fld};
    low = addr[FLD_W-1:0];
    if (low == FLD_W'(IND_OFS))       kind = K_NULL;
    else if (low == FLD_W'(STAT_OFS)) kind = K_STAT;
    else if (low == FLD_W'(PTR_OFS))  kind = K_PTR;
    else                              kind = K_RAM;
  end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single-clock array, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rf_ctrl_regs.sv
module rf_ctrl_regs
  import banked_rf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_we,
  input  logic              ptr_we,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              alu_we,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [DW-1:0]     status_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [DW-1:0]     stat_nxt,
  output logic [PTR_W-1:0]  ptr_nxt
);

  always_comb begin
    stat_nxt = status_q;
    if (stat_we) stat_nxt[DW-1:FLAG_W] = bus_wdata[DW-1:FLAG_W];
    if (alu_we)  stat_nxt[FLAG_W-1:0]  = alu_flags;
    ptr_nxt = ptr_we ? bus_wdata[PTR_W-1:0] : ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ptr_q    <= '0;
    end else begin
      status_q <= stat_nxt;
      ptr_q    <= ptr_nxt;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_q == '0 && ptr_q == '0));

  // R7
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alu_we)) |-> status_q[FLAG_W-1:0] == $past(alu_flags));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(alu_we)) |-> status_q[FLAG_W-1:0] == $past(status_q[FLAG_W-1:0]));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stat_we)) |-> status_q[DW-1:FLAG_W] == $past(status_q[DW-1:FLAG_W]));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ptr_we)) |-> ptr_q == $past(ptr_q));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DW       = 8,
  parameter int FLD_W    = 7,
  parameter int BANK_W   = 2,
  parameter int PTR_W    = 8,
  parameter int IND_OFS  = 0,
  parameter int STAT_OFS = 3,
  parameter int PTR_OFS  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_vld,
  input  logic [1:0]             req_op,
  input  logic [FLD_W-1:0]       req_fld,
  input  logic [DW-1:0]          req_wdata,
  input  logic [$clog2(DW)-1:0]  req_bit,
  input  logic                   alu_flag_we,
  input  logic [FLAG_W-1:0]      alu_flags,
  output logic                   rd_vld,
  output logic [DW-1:0]          rd_data,
  output logic [DW-1:0]          status_q,
  output logic [PTR_W-1:0]       ptr_q
);
  localparam int AW    = FLD_W + BANK_W;
  localparam int BIT_W = $clog2(DW);

  // stage 0: address formation from committed-or-committing state
  logic [DW-1:0]    stat_nxt;
  logic [PTR_W-1:0] ptr_nxt;
  logic [AW-1:0]    a0_addr;
  rf_kind_e         a0_kind;

  rf_addr_gen #(
    .DW(DW), .FLD_W(FLD_W), .BANK_W(BANK_W), .PTR_W(PTR_W),
    .IND_OFS(IND_OFS), .STAT_OFS(STAT_OFS), .PTR_OFS(PTR_OFS)
  ) u_agen (
    .fld  (req_fld),
    .stat (stat_nxt),
    .ptr  (ptr_nxt),
    .addr (a0_addr),
    .kind (a0_kind)
  );

  // stage 1 registers
  logic             s1_vld;
  rf_op_e           s1_op;
  rf_kind_e         s1_kind;
  logic [AW-1:0]    s1_addr;
  logic [DW-1:0]    s1_wdata;
  logic [BIT_W-1:0] s1_bit;
  logic             fwd_hit;
  logic [DW-1:0]    fwd_data;

  logic [DW-1:0] ram_q;
  logic [DW-1:0] cur_byte;
  logic [DW-1:0] new_byte;
  logic [DW-1:0] bmask;
  logic          wr_any;
  logic          ram_we;
  logic          stat_we;
  logic          ptr_we;
  logic          s1_rd;

  always_comb begin
    unique case (s1_kind)
      K_NULL:  cur_byte = '0;
      K_STAT:  cur_byte = status_q;
      K_PTR:   cur_byte = DW'(ptr_q);
      default: cur_byte = fwd_hit ? fwd_data : ram_q;
    endcase
    bmask = DW'(1) << s1_bit;
    unique case (s1_op)
      OP_WR:   new_byte = s1_wdata;
      OP_BSET: new_byte = cur_byte | bmask;
      OP_BCLR: new_byte = cur_byte & ~bmask;
      default: new_byte = cur_byte;
    endcase
    s1_rd   = s1_vld && (s1_op == OP_RD);
    wr_any  = s1_vld && (s1_op != OP_RD);
    ram_we  = wr_any && (s1_kind == K_RAM);
    stat_we = wr_any && (s1_kind == K_STAT);
    ptr_we  = wr_any && (s1_kind == K_PTR);
  end

  rf_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .we    (ram_we),
    .waddr (s1_addr),
    .wdata (new_byte),
    .raddr (a0_addr),
    .rdata (ram_q)
  );

  rf_ctrl_regs #(.DW(DW), .PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .stat_we   (stat_we),
    .ptr_we    (ptr_we),
    .bus_wdata (new_byte),
    .alu_we    (alu_flag_we),
    .alu_flags (alu_flags),
    .status_q  (status_q),
    .ptr_q     (ptr_q),
    .stat_nxt  (stat_nxt),
    .ptr_nxt   (ptr_nxt)
  );

  // control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      rd_vld  <= 1'b0;
      fwd_hit <= 1'b0;
      s1_op   <= OP_RD;
      s1_kind <= K_RAM;
    end else begin
      s1_vld  <= req_vld;
      rd_vld  <= s1_rd;
      fwd_hit <= ram_we && req_vld && (a0_kind == K_RAM) && (a0_addr == s1_addr);
      s1_op   <= rf_op_e'(req_op);
      s1_kind <= a0_kind;
    end
  end

  // payload without reset
  always_ff @(posedge clk) begin
    s1_addr  <= a0_addr;
    s1_wdata <= req_wdata;
    s1_bit   <= req_bit;
    fwd_data <= new_byte;
    if (s1_rd) rd_data <= cur_byte;
  end

  // R5
  null_read_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_op == OP_RD && s1_kind == K_NULL) |=> (rd_vld && rd_data == '0));

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_op == 2'd0) |=> ##1 rd_vld);

  // R10
  rd_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_vld && req_op == 2'd0) |=> ##1 !rd_vld);

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_vld;
  logic [1:0] req_op;
  logic [6:0] req_fld;
  logic [7:0] req_wdata;
  logic [2:0] req_bit;
  logic       alu_flag_we;
  logic [2:0] alu_flags;
  logic       rd_vld;
  logic [7:0] rd_data;
  logic [7:0] status_q;
  logic [7:0] ptr_q;

  always #5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_op(req_op),
    .req_fld(req_fld), .req_wdata(req_wdata), .req_bit(req_bit),
    .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
    .rd_vld(rd_vld), .rd_data(rd_data), .status_q(status_q), .ptr_q(ptr_q)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0] mem_m [512];
  logic [7:0] st_m;
  logic [7:0] ptr_m;
  logic [7:0] exp_q[$];
  int         cy_q[$];
  string      tg_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // result checker, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (exp_q.size() == 0) chk("R10 rd_vld without a read", 8'd1, 8'd0);
      else begin
        chk(tg_q.pop_front(), rd_data, exp_q.pop_front());
        chk("R8 read latency", 8'(cyc - cy_q.pop_front()), 8'd2);
      end
    end
  end

  // one request per call, model updated in request order
  task automatic issue(input logic [1:0] op, input logic [6:0] fld, input logic [7:0] wd,
                       input logic [2:0] b, input string tag,
                       input logic awe = 1'b0, input logic [2:0] af = 3'd0);
    logic [8:0] ea;
    logic [7:0] cur;
    logic [7:0] nv;
    @(negedge clk);
    req_vld = 1'b1; req_op = op; req_fld = fld; req_wdata = wd; req_bit = b;
    alu_flag_we = awe; alu_flags = af;
    if (awe) st_m[2:0] = af;
    ea = (fld == 7'd0) ? {st_m[7], ptr_m} : {st_m[6:5], fld};
    if (ea[6:0] == 7'd0)      cur = 8'h00;
    else if (ea[6:0] == 7'd3) cur = st_m;
    else if (ea[6:0] == 7'd4) cur = ptr_m;
    else                      cur = mem_m[ea];
    case (op)
      2'd1:    nv = wd;
      2'd2:    nv = cur | (8'd1 << b);
      2'd3:    nv = cur & ~(8'd1 << b);
      default: nv = cur;
    endcase
    if (op == 2'd0) begin
      exp_q.push_back(cur); cy_q.push_back(cyc); tg_q.push_back(tag);
    end else if (ea[6:0] == 7'd3) st_m[7:3] = nv[7:3];
    else if (ea[6:0] == 7'd4) ptr_m = nv;
    else if (ea[6:0] != 7'd0) mem_m[ea] = nv;
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0; alu_flag_we = 1'b0;
  endtask

  initial begin
    req_vld = 0; req_op = 0; req_fld = 0; req_wdata = 0; req_bit = 0;
    alu_flag_we = 0; alu_flags = 0;
    st_m = 0; ptr_m = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", status_q, 8'h00);
    chk("R1 pointer after reset", ptr_q, 8'h00);
    chk("R1 rd_vld after reset", {7'd0, rd_vld}, 8'h00);

    // R2: fill every bank directly, then read all back
    for (int bk = 0; bk < 4; bk++) begin
      issue(2'd1, 7'd3, {1'b0, 2'(bk), 5'd0}, 3'd0, "R2");
      for (int f = 1; f < 128; f++)
        if (f != 3 && f != 4) issue(2'd1, 7'(f), 8'(bk * 37 + f * 13 + 5), 3'd0, "R2");
    end
    for (int bk = 0; bk < 4; bk++) begin
      issue(2'd1, 7'd3, {1'b0, 2'(bk), 5'd0}, 3'd0, "R2");
      for (int f = 1; f < 128; f++)
        if (f != 3 && f != 4) issue(2'd0, 7'(f), 8'd0, 3'd0, "R2 direct read");
    end

    // R4: specials mirrored in each bank
    for (int bk = 0; bk < 4; bk++) begin
      issue(2'd1, 7'd3, {1'b0, 2'(bk), 5'd0}, 3'd0, "R4");
      issue(2'd0, 7'd3, 8'd0, 3'd0, "R4 status mirror");
      issue(2'd1, 7'd4, 8'(bk * 16 + 7), 3'd0, "R4");
      issue(2'd0, 7'd4, 8'd0, 3'd0, "R4 pointer mirror");
    end

    // R3/R5/R9: every pointer value in both halves, read right after the pointer write
    for (int irp = 0; irp < 2; irp++) begin
      issue(2'd1, 7'd3, {1'(irp), 7'd0}, 3'd0, "R3");
      for (int p = 0; p < 256; p++) begin
        issue(2'd1, 7'd4, 8'(p), 3'd0, "R3");
        issue(2'd0, 7'd0, 8'd0, 3'd0, (p % 128 == 0) ? "R5 null read" : "R3 indirect read");
      end
    end

    // R3: writes through the pointer, checked directly
    foreach (exp_q[i]) ; // no-op keeps queue order untouched
    for (int k = 0; k < 3; k++) begin
      logic [7:0] p;
      p = (k == 0) ? 8'h10 : (k == 1) ? 8'h55 : 8'hFE;
      issue(2'd1, 7'd3, 8'h80, 3'd0, "R3");
      issue(2'd1, 7'd4, p, 3'd0, "R3");
      issue(2'd1, 7'd0, ~p, 3'd0, "R3 indirect write");
      issue(2'd1, 7'd3, {1'b1, 1'b1, p[7], 5'd0}, 3'd0, "R3");
      issue(2'd0, p[6:0], 8'd0, 3'd0, "R3 indirect write seen directly");
    end

    // R5: writes to the null target change nothing
    issue(2'd1, 7'd3, 8'h00, 3'd0, "R5");
    issue(2'd1, 7'd4, 8'h00, 3'd0, "R5");
    issue(2'd1, 7'd0, 8'h5A, 3'd0, "R5 null write");
    issue(2'd2, 7'd0, 8'h00, 3'd2, "R5 null set bit");
    issue(2'd0, 7'd3, 8'd0, 3'd0, "R5 status untouched");
    issue(2'd0, 7'd4, 8'd0, 3'd0, "R5 pointer untouched");
    issue(2'd0, 7'd0, 8'd0, 3'd0, "R5 null read");
    issue(2'd1, 7'd3, 8'h80, 3'd0, "R5");
    issue(2'd1, 7'd4, 8'h80, 3'd0, "R5");
    issue(2'd1, 7'd0, 8'hA5, 3'd0, "R5 null write upper half");
    issue(2'd0, 7'd4, 8'd0, 3'd0, "R5 pointer untouched");
    issue(2'd0, 7'd3, 8'd0, 3'd0, "R5 status untouched");

    // R6: bit set and clear, back to back
    issue(2'd1, 7'd3, 8'h40, 3'd0, "R6");
    issue(2'd1, 7'h40, 8'h00, 3'd0, "R6");
    for (int b = 0; b < 8; b++) begin
      issue(2'd2, 7'h40, 8'h00, 3'(b), "R6");
      issue(2'd0, 7'h40, 8'd0, 3'd0, "R6 set bit");
    end
    for (int b = 0; b < 8; b++) begin
      issue(2'd3, 7'h40, 8'h00, 3'(7 - b), "R6");
      if (b % 2 == 1) issue(2'd0, 7'h40, 8'd0, 3'd0, "R6 clear bit");
    end
    issue(2'd1, 7'h41, 8'h96, 3'd0, "R6");
    issue(2'd2, 7'h41, 8'h00, 3'd0, "R6");
    issue(2'd3, 7'h41, 8'h00, 3'd7, "R6");
    issue(2'd0, 7'h41, 8'd0, 3'd0, "R6 mixed bit ops");
    issue(2'd1, 7'd4, 8'h00, 3'd0, "R6");
    issue(2'd2, 7'd4, 8'h00, 3'd5, "R6");
    issue(2'd0, 7'd0, 8'd0, 3'd0, "R6 pointer bit set then indirect");

    // R7: ALU flags and bus status writes in the same cycle
    issue(2'd1, 7'd3, 8'hFF, 3'd0, "R7", 1'b1, 3'b101);
    issue(2'd0, 7'd3, 8'd0, 3'd0, "R7 bus and flag write together");
    issue(2'd2, 7'd3, 8'h00, 3'd1, "R7");
    issue(2'd0, 7'd3, 8'd0, 3'd0, "R7 bus cannot set a flag");
    issue(2'd0, 7'd3, 8'd0, 3'd0, "R7 flag load seen by read", 1'b1, 3'b010);
    issue(2'd3, 7'd3, 8'h00, 3'd7, "R7", 1'b1, 3'b111);
    issue(2'd0, 7'd3, 8'd0, 3'd0, "R7 bit clear with flag load");
    issue(2'd1, 7'd3, 8'h00, 3'd0, "R7");
    issue(2'd0, 7'd3, 8'd0, 3'd0, "R7 bus cannot clear flags");

    // R9: dependent accesses with no gap
    issue(2'd1, 7'd3, 8'h20, 3'd0, "R9");
    issue(2'd1, 7'h22, 8'hC3, 3'd0, "R9");
    issue(2'd0, 7'h22, 8'd0, 3'd0, "R9 read after write");
    issue(2'd1, 7'd3, 8'h60, 3'd0, "R9");
    issue(2'd0, 7'h22, 8'd0, 3'd0, "R9 bank switch then read");
    issue(2'd1, 7'h22, 8'h0F, 3'd0, "R9");
    issue(2'd2, 7'h22, 8'h00, 3'd6, "R9");
    issue(2'd3, 7'h22, 8'h00, 3'd0, "R9");
    issue(2'd0, 7'h22, 8'd0, 3'd0, "R9 chained read-modify-writes");
    issue(2'd1, 7'd4, 8'hA2, 3'd0, "R9");
    issue(2'd0, 7'd0, 8'd0, 3'd0, "R9 pointer write then indirect read");

    idle();
    repeat (4) @(negedge clk);
    chk("R10 all reads answered", 8'(exp_q.size()), 8'd0);
    chk("R10 rd_vld low when idle", {7'd0, rd_vld}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule